// File: doc/BRIEF.md
# Byte-Wide Non-Volatile RAM Access Controller

This block is a synchronous front end for an asynchronous, byte-wide non-volatile RAM that is controlled through active-low select, write-strobe and output-enable pins. A host issues one access at a time on a request/acknowledge port. The host holds `req` high with the address, direction and write byte until it sees a one-cycle `ack`. The controller then drives the memory pins in the correct order. Each access is held open for a minimum time, which is converted into a clock count from the clock frequency parameter. The data bus is split into output, output-enable and input, so the pad ring can merge them into a bidirectional pin.

A power-good input gates all activity. Each time power-good rises, the controller waits a full startup window with the select and write strobes held inactive. Only then does it start any access. If power-good drops, any access in flight is cut off without an acknowledge, and the window starts over when power returns. A request left pending through the outage is served once the new window has ended.

Top module: `nvram_ctrl`

## Requirements
- R1: During and straight after reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `ack` are 0.
- R2: A read (`req_we`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly CYC clocks. `mem_dq_i` is captured on the last of those clocks and appears on `rdata`, together with an `ack` that lasts one clock.
- R3: A write (`req_we`=1) first spends one setup clock with `mem_ce_n`=0, `mem_we_n`=1 and `mem_dq_oe`=1. It then holds `mem_we_n`=0 for exactly CYC clocks while driving `req_wdata` on `mem_dq_o`, so `mem_ce_n` is low for CYC+1 clocks. A single `ack` clock follows.
- R4: `mem_oe_n` is never 0 while `mem_we_n` is 0 or `mem_dq_oe` is 1.
- R5: CYC = ceil(MIN_CYCLE_NS x CLK_MHZ / 1000), with a minimum of 1. With 35 ns at 100 MHz this gives 4.
- R6: `mem_ce_n` is 1 in the clock that carries `ack`, so successive accesses are separated by at least one deselected clock.
- R7: After `pwr_good` rises, `mem_ce_n` and `mem_we_n` stay 1. If a request is pending, its access begins SYNC_STAGES + STARTUP_US x CLK_MHZ + 1 clocks after the rise.
- R8: A request made while `pwr_good` is 0 gets no `ack` and causes no pin activity.
- R9: When `pwr_good` falls, `mem_ce_n` and `mem_we_n` are forced to 1 within SYNC_STAGES clocks and the access gets no `ack`. After `pwr_good` returns, a still-pending request is retried only once a full new window has passed.
- R10: `mem_addr` is stable for as long as `mem_ce_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply valid indication, asynchronous |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read byte, valid with ack |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The bench builds the controller with CLK_MHZ=100, MIN_CYCLE_NS=35, STARTUP_US=1 and SYNC_STAGES=2. This gives a four-clock access, which does not divide evenly and so exercises the rounding up, and a 100-clock startup window. The short window lets the bench count the exact startup latency both at first power-up and after a brownout that cuts a write short. The address set covers both ends of the 19-bit range and a mid-range pattern.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WSU   = 3'd2,
    ST_WR    = 3'd3,
    ST_ACK   = 3'd4
  } nv_state_e;

  // clocks needed to cover a minimum time, rounded up, never below one
  function automatic int unsigned min_clks(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/nvram_pwr_gate.sv
module nvram_pwr_gate #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STARTUP_CLKS = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic armed
);

  localparam int unsigned CW = $clog2(STARTUP_CLKS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(STARTUP_CLKS);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   pg_s;
  logic                   cnt_en;

  assign pg_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pwr_good};
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!pg_s) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CNT_FULL) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign armed = pg_s && (cnt_q == CNT_FULL);

  AST_OUTAGE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> !armed); // R9

endmodule

// File: rtl/nvram_access_fsm.sv
module nvram_access_fsm
  import nvram_pkg::*;
#(
  parameter int unsigned AW       = 19,
  parameter int unsigned DW       = 8,
  parameter int unsigned CYC_CLKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int unsigned CCW = $clog2(CYC_CLKS + 1);
  localparam logic [CCW-1:0] CYC_LAST = CCW'(CYC_CLKS - 1);

  nv_state_e     st_q, st_d;
  logic [CCW-1:0] cyc_q, cyc_d;
  logic          lat_en, cap_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    lat_en = 1'b0;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req && armed) begin
          lat_en = 1'b1;
          cyc_d  = '0;
          st_d   = req_we ? ST_WSU : ST_RD;
        end
      end
      ST_RD: begin
        if (!armed) begin
          st_d = ST_IDLE;
        end else if (cyc_q == CYC_LAST) begin
          cap_en = 1'b1;
          st_d   = ST_ACK;
        end else begin
          cyc_d = cyc_q + 1'b1;
        end
      end
      ST_WSU: begin
        if (!armed) begin
          st_d = ST_IDLE;
        end else begin
          cyc_d = '0;
          st_d  = ST_WR;
        end
      end
      ST_WR: begin
        if (!armed) begin
          st_d = ST_IDLE;
        end else if (cyc_q == CYC_LAST) begin
          st_d = ST_ACK;
        end else begin
          cyc_d = cyc_q + 1'b1;
        end
      end
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
    end else begin
      st_q  <= st_d;
      cyc_q <= cyc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (lat_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= mem_dq_i;
    end
  end

  // pin decode, gated by power state so an outage forces strobes inactive
  assign mem_ce_n  = !(armed && (st_q == ST_RD || st_q == ST_WSU || st_q == ST_WR));
  assign mem_we_n  = !(armed && st_q == ST_WR);
  assign mem_oe_n  = !(armed && st_q == ST_RD);
  assign mem_dq_oe = armed && (st_q == ST_WSU || st_q == ST_WR);
  assign mem_dq_o  = wdata_q;
  assign mem_addr  = addr_q;
  assign ack       = (st_q == ST_ACK);
  assign rdata     = rdata_q;

  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe) && $past(!mem_ce_n)); // R3

  AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R2

  AST_ACK_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> mem_ce_n); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R4

endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
  import nvram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned MIN_CYCLE_NS = 35,
  parameter int unsigned STARTUP_US   = 2000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned CYC_CLKS     = min_clks(MIN_CYCLE_NS, CLK_MHZ); // R5
  localparam int unsigned STARTUP_CLKS = STARTUP_US * CLK_MHZ;

  logic armed;

  nvram_pwr_gate #(
    .SYNC_STAGES (SYNC_STAGES),
    .STARTUP_CLKS(STARTUP_CLKS)
  ) u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_good(pwr_good),
    .armed   (armed)
  );

  nvram_access_fsm #(
    .AW      (ADDR_W),
    .DW      (DATA_W),
    .CYC_CLKS(CYC_CLKS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .req      (req),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ack      (ack),
    .rdata    (rdata),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe),
    .mem_dq_i (mem_dq_i)
  );

  AST_POWER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (mem_ce_n && mem_we_n)); // R7

  AST_ACK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(armed)); // R9

endmodule

// File: tb/sim_nvram_ctrl.sv
module sim_nvram_ctrl;

  localparam int CLK_PERIOD_NS = 10;
  localparam int CLK_MHZ       = 100;
  localparam int STARTUP_US    = 1;
  localparam int SYNC          = 2;
  localparam int STARTUP       = STARTUP_US * CLK_MHZ;
  localparam int CYC           = (35 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int GATE_LAT      = STARTUP + SYNC + 1;
  localparam int NVEC          = 8;

  // {write, addr, wdata, expected read}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 19'h00000, 8'hA5, 8'h00},
    {1'b1, 19'h7FFFF, 8'h3C, 8'h00},
    {1'b1, 19'h12345, 8'hF0, 8'h00},
    {1'b0, 19'h00000, 8'h00, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h00, 8'h3C},
    {1'b0, 19'h12345, 8'h00, 8'hF0},
    {1'b1, 19'h00000, 8'h5A, 8'h00},
    {1'b0, 19'h00000, 8'h00, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n, pwr_good, req, req_we;
  logic [18:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rdata, mem_dq_o, mem_dq_i;
  logic        ack, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int total = 0;
  int bad   = 0;

  // memory model, aliased on the low address nibble (test addresses differ there)
  logic [7:0] bmem [16];
  int ce_run, ce_last, we_run, we_last, oe_run, oe_last, ack_cnt;
  logic prev_we_n, prev_dq_oe, setup_bad, contention, addr_bad;
  logic [18:0] watch_addr;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  nvram_ctrl #(
    .CLK_MHZ(CLK_MHZ), .MIN_CYCLE_NS(35), .STARTUP_US(STARTUP_US), .SYNC_STAGES(SYNC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? bmem[mem_addr[3:0]] : 8'hEE;

  always @(negedge clk) begin
    if (!mem_ce_n) ce_run++; else if (ce_run != 0) begin ce_last = ce_run; ce_run = 0; end
    if (!mem_we_n) we_run++; else if (we_run != 0) begin we_last = we_run; we_run = 0; end
    if (!mem_oe_n) oe_run++; else if (oe_run != 0) begin oe_last = oe_run; oe_run = 0; end
    if (!mem_we_n && prev_we_n && !prev_dq_oe) setup_bad = 1'b1;
    if (!mem_oe_n && (!mem_we_n || mem_dq_oe)) contention = 1'b1;
    if (!mem_ce_n && mem_addr != watch_addr) addr_bad = 1'b1;
    if (ack) ack_cnt++;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) bmem[mem_addr[3:0]] = mem_dq_o;
    prev_we_n  = mem_we_n;
    prev_dq_oe = mem_dq_oe;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ack && n < 1000);
  endtask

  task automatic access(input bit we, input logic [18:0] a, input logic [7:0] d,
                        input logic [7:0] exp);
    int n, a0;
    setup_bad = 0; contention = 0; addr_bad = 0;
    a0 = ack_cnt;
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; watch_addr = a;
    wait_ack(n);
    check(ack, "R2 ack arrives", ack, 1);
    check(mem_ce_n, "R6 deselect with ack", mem_ce_n, 1);
    if (!we) check(rdata == exp, "R2 read data", rdata, exp);
    req = 1'b0;
    @(negedge clk); @(negedge clk);
    check(ack_cnt - a0 == 1, "R2 ack one clock", ack_cnt - a0, 1);
    check(!contention, "R4 no contention", contention, 0);
    check(!addr_bad, "R10 address held", addr_bad, 0);
    if (we) begin
      check(we_last == CYC, "R3 R5 write strobe length", we_last, CYC);
      check(ce_last == CYC + 1, "R3 select length", ce_last, CYC + 1);
      check(!setup_bad, "R3 data setup clock", setup_bad, 0);
    end else begin
      check(oe_last == CYC, "R2 R5 read enable length", oe_last, CYC);
      check(ce_last == CYC, "R2 select length", ce_last, CYC);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) bmem[i] = 8'h00;
    ce_run = 0; ce_last = 0; we_run = 0; we_last = 0; oe_run = 0; oe_last = 0; ack_cnt = 0;
    prev_we_n = 1; prev_dq_oe = 0; setup_bad = 0; contention = 0; addr_bad = 0;
    watch_addr = '0;
    rst_n = 0; pwr_good = 0; req = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle in reset",
          {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    check(!mem_dq_oe && !ack, "R1 no drive no ack", {mem_dq_oe, ack}, 0);
    rst_n = 1;

    // R8: request with power absent
    req = 1; req_we = 0; req_addr = 19'h00000; watch_addr = 19'h00000;
    repeat (30) @(negedge clk);
    check(ack_cnt == 0, "R8 no ack without power", ack_cnt, 0);
    check(ce_run == 0 && ce_last == 0, "R8 no select without power", ce_run, 0);

    // R7: startup window length
    pwr_good = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (mem_ce_n && n < 1000);
    check(n == GATE_LAT, "R7 startup latency", n, GATE_LAT);
    wait_ack(n);
    check(ack && rdata == 8'h00, "R7 first read after window", rdata, 0);
    req = 0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][35], VEC[v][34:16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R9: brownout during a write
    n = ack_cnt;
    req = 1; req_we = 1; req_addr = 19'h2AAAA; req_wdata = 8'h77; watch_addr = 19'h2AAAA;
    do @(negedge clk); while (mem_we_n);
    pwr_good = 0;
    repeat (SYNC) @(negedge clk);
    check(mem_ce_n && mem_we_n, "R9 strobes forced off", {mem_ce_n, mem_we_n}, 2'b11);
    repeat (10) @(negedge clk);
    check(ack_cnt == n, "R9 aborted access no ack", ack_cnt - n, 0);
    pwr_good = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (mem_ce_n && n < 1000);
    check(n == GATE_LAT, "R9 window restarted", n, GATE_LAT);
    wait_ack(n);
    req = 0;
    repeat (2) @(negedge clk);
    access(1'b0, 19'h2AAAA, 8'h00, 8'h77); // R9 retried write landed

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule